// File: doc/BRIEF.md
# Two-Stage Set-Associative Instruction Fetch Cache

This block is a read-only instruction cache that sits between an instruction-fetch unit and a memory bus. The core offers a virtual fetch address on a ready/valid port. The translated physical address follows one cycle later. The tag and data arrays are read in the request cycle using the index bits, which are the same in the virtual and the physical address. In the next cycle the stored tags are compared with the late physical address and the per-line valid flops are checked. The selected 32-bit word leaves the block one cycle after that, together with a valid flag.

A lookup that misses returns nothing, and the fetch unit retries. The cache then fetches the whole line over a narrow fill bus. That bus has a request channel carrying a line-aligned address and a response channel that delivers 64-bit beats. A free-running LFSR picks the way that the new line replaces, and only one refill is in flight at a time. A single invalidate input drops every line at once; it is the hook for an instruction-fence operation. Two kill inputs let the core cancel an access while it is in the compare stage or in the response stage.

The default geometry is 64 sets, 4 ways, 64-byte lines and 32-bit physical addresses. The tag is therefore physical address bits [31:12] and the set index is bits [11:6].

Top module: `icache_pipe`

## Requirements
- R1: After a synchronous reset, every line is invalid. `insn_valid` and `fill_req_valid` are low and `fetch_ready` is high.
- R2: A lookup that misses gives no response and raises `fill_req_valid` with `fill_req_addr` equal to the physical address with bits [5:0] cleared. The request is issued exactly once, and address and valid hold steady until `fill_req_ready`.
- R3: A refill takes 8 beats. Beat k carries bytes 8k..8k+7 of the line, and the word at address bit 2 = 1 is the upper half of its beat. After the refill, a fetch is accepted at a clock edge, its physical address is presented in the next cycle, and `insn_valid` is high with the 32-bit word at that physical address in the cycle after that.
- R4: Hit or miss is decided only by the late physical address tag (bits [31:12]). Virtual address bits above bit 11 have no effect. A different physical tag in the same set misses.
- R5: `fetch_ready` is low from the accepted fill request until the refilled line has been written, so it is low whenever a beat arrives.
- R6: `kill_lookup`, when high in the compare cycle, cancels that access: it gives no response and no fill request.
- R7: `kill_resp`, when high in the response cycle, cancels that access: it gives no response, even on a hit, and no fill request.
- R8: A one-cycle pulse on `inv_all` invalidates every way of every set. Lookups whose compare cycle comes after the pulse miss.
- R9: If `inv_all` pulses while a refill is in progress, the refilled line is not marked valid, and a later fetch of it misses again.
- R10: The refill victim comes from an LFSR. Right after its refill a line hits. A set never holds more than 4 distinct tags, and lines in other sets are left untouched.
- R11: Only one refill is outstanding. A miss that occurs while a refill is in progress gives no response and issues no second fill request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch request valid |
| fetch_ready | output | 1 | Cache can accept a fetch |
| fetch_vaddr | input | VA_W | Virtual fetch address (index and word bits used) |
| lk_paddr | input | PA_W | Physical address, one cycle after acceptance |
| kill_lookup | input | 1 | Cancel the access in the compare stage |
| kill_resp | input | 1 | Cancel the access in the response stage |
| inv_all | input | 1 | Invalidate all lines |
| insn_valid | output | 1 | Response word valid |
| insn_word | output | 32 | Fetched instruction word |
| fill_req_valid | output | 1 | Line fill request valid |
| fill_req_ready | input | 1 | Memory accepts the fill request |
| fill_req_addr | output | PA_W | Line-aligned fill address |
| fill_beat_valid | input | 1 | Fill data beat valid |
| fill_beat_data | input | BEAT_W | Fill data beat |

## Verification
The bench sweeps all 64 sets and checks every word offset of several lines. If the beat order or the half-word selection were wrong, the bench would see shuffled words rather than just a wrong line. It separates the virtual from the physical tag bits, so a design that compared the wrong address would hit falsely. It cancels accesses in each of the two stages, on both cached and uncached lines; a wrongly wired kill would either leak a response or start a refill. It holds the fill request unaccepted while it issues a second miss and while it pulses invalidate. A controller that accepted a second miss would raise a duplicate request, and one that ignored the invalidate would let the stale line hit.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int INSN_W = 32;

    typedef enum logic [1:0] {
        RF_IDLE    = 2'd0,
        RF_ISSUE   = 2'd1,
        RF_COLLECT = 2'd2,
        RF_DONE    = 2'd3
    } refill_st_e;

    // Fibonacci step, taps 8,6,5,4 (maximal length for 8 bits)
    function automatic logic [7:0] lfsr8_step(input logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

endpackage

// File: rtl/icache_lfsr.sv
module icache_lfsr (
    input  logic       clk,
    input  logic       rst,
    output logic [7:0] state
);
    import icache_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) state <= 8'h01;
        else     state <= lfsr8_step(state);
    end
endmodule

// File: rtl/icache_tag_store.sv
module icache_tag_store #(
    parameter int SETS  = 64,
    parameter int WAYS  = 4,
    parameter int TAG_W = 20
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(SETS)-1:0]  rd_set,
    output logic [WAYS*TAG_W-1:0]    rd_tags,
    input  logic [$clog2(SETS)-1:0]  chk_set,
    output logic [WAYS-1:0]          chk_vld,
    input  logic                     upd_en,
    input  logic [$clog2(SETS)-1:0]  upd_set,
    input  logic [$clog2(WAYS)-1:0]  upd_way,
    input  logic [TAG_W-1:0]         upd_tag,
    input  logic                     mark_en,
    input  logic [$clog2(SETS)-1:0]  mark_set,
    input  logic [$clog2(WAYS)-1:0]  mark_way,
    input  logic                     inv_all
);
    logic [WAYS*TAG_W-1:0] tags [SETS];
    logic [WAYS-1:0]       vld  [SETS];

    // synchronous-read tag array, read every cycle at the request index
    always_ff @(posedge clk) begin
        if (upd_en) tags[upd_set][upd_way*TAG_W +: TAG_W] <= upd_tag;
        rd_tags <= tags[rd_set];
    end

    // valid flops: invalidate-all has priority over the refill marking
    always_ff @(posedge clk) begin
        if (rst || inv_all) begin
            for (int s = 0; s < SETS; s++) vld[s] <= '0;
        end else begin
            if (upd_en)  vld[upd_set][upd_way]   <= 1'b0;
            if (mark_en) vld[mark_set][mark_way] <= 1'b1;
        end
    end

    assign chk_vld = vld[chk_set];
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store #(
    parameter int SETS   = 64,
    parameter int WAYS   = 4,
    parameter int BEATS  = 8,
    parameter int BEAT_W = 64
) (
    input  logic                      clk,
    input  logic [$clog2(SETS)-1:0]   rd_set,
    input  logic [$clog2(BEATS)-1:0]  rd_beat,
    output logic [WAYS*BEAT_W-1:0]    rd_row,
    input  logic                      wr_en,
    input  logic [$clog2(SETS)-1:0]   wr_set,
    input  logic [$clog2(BEATS)-1:0]  wr_beat,
    input  logic [$clog2(WAYS)-1:0]   wr_way,
    input  logic [BEAT_W-1:0]         wr_data
);
    localparam int WAY_W = $clog2(WAYS);

    // one array; each row holds the same beat of all ways side by side
    logic [WAYS*BEAT_W-1:0] mem [SETS*BEATS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (wr_way == WAY_W'(w))
                    mem[{wr_set, wr_beat}][w*BEAT_W +: BEAT_W] <= wr_data;
            end
        end
        rd_row <= mem[{rd_set, rd_beat}];
    end
endmodule

// File: rtl/icache_refill_ctl.sv
module icache_refill_ctl #(
    parameter int LINE_W = 26,
    parameter int WAY_W  = 2,
    parameter int BEATS  = 8,
    parameter int BEAT_W = 64,
    parameter int OFF_W  = 6
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      miss,
    input  logic [LINE_W-1:0]         miss_line,
    input  logic [WAY_W-1:0]          victim_in,
    input  logic                      inv_all,
    output logic                      fill_req_valid,
    input  logic                      fill_req_ready,
    output logic [LINE_W+OFF_W-1:0]   fill_req_addr,
    input  logic                      fill_beat_valid,
    input  logic [BEAT_W-1:0]         fill_beat_data,
    output icache_pkg::refill_st_e    st_o,
    output logic                      busy,
    output logic                      upd_en,
    output logic                      mark_en,
    output logic [LINE_W-1:0]         tgt_line,
    output logic [WAY_W-1:0]          tgt_way,
    output logic                      wr_en,
    output logic [$clog2(BEATS)-1:0]  wr_beat,
    output logic [BEAT_W-1:0]         wr_data
);
    import icache_pkg::*;

    localparam int CNT_W = $clog2(BEATS);

    refill_st_e        st;
    logic [LINE_W-1:0] line_q;
    logic [WAY_W-1:0]  way_q;
    logic [CNT_W-1:0]  cnt;
    logic              aborted;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RF_IDLE;
            line_q  <= '0;
            way_q   <= '0;
            cnt     <= '0;
            aborted <= 1'b0;
        end else begin
            case (st)
                RF_IDLE: if (miss) begin
                    st      <= RF_ISSUE;
                    line_q  <= miss_line;
                    way_q   <= victim_in;
                    aborted <= 1'b0;
                end
                RF_ISSUE: if (fill_req_ready) begin
                    st  <= RF_COLLECT;
                    cnt <= '0;
                end
                RF_COLLECT: if (fill_beat_valid) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(BEATS - 1)) st <= RF_DONE;
                end
                default: st <= RF_IDLE;
            endcase
            if (inv_all && st != RF_IDLE) aborted <= 1'b1;
        end
    end

    assign st_o           = st;
    assign busy           = (st == RF_COLLECT) || (st == RF_DONE);
    assign upd_en         = (st == RF_IDLE) && miss;
    assign mark_en        = (st == RF_DONE) && !aborted && !inv_all;
    assign tgt_line       = (st == RF_IDLE) ? miss_line : line_q;
    assign tgt_way        = (st == RF_IDLE) ? victim_in : way_q;
    assign fill_req_valid = (st == RF_ISSUE);
    assign fill_req_addr  = {line_q, {OFF_W{1'b0}}};
    assign wr_en          = (st == RF_COLLECT) && fill_beat_valid;
    assign wr_beat        = cnt;
    assign wr_data        = fill_beat_data;
endmodule

// File: rtl/icache_pipe.sv
module icache_pipe #(
    parameter int SETS       = 64,
    parameter int WAYS       = 4,
    parameter int LINE_BYTES = 64,
    parameter int PA_W       = 32,
    parameter int VA_W       = 32,
    parameter int BEAT_W     = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_valid,
    output logic              fetch_ready,
    input  logic [VA_W-1:0]   fetch_vaddr,
    input  logic [PA_W-1:0]   lk_paddr,
    input  logic              kill_lookup,
    input  logic              kill_resp,
    input  logic              inv_all,
    output logic              insn_valid,
    output logic [31:0]       insn_word,
    output logic              fill_req_valid,
    input  logic              fill_req_ready,
    output logic [PA_W-1:0]   fill_req_addr,
    input  logic              fill_beat_valid,
    input  logic [BEAT_W-1:0] fill_beat_data
);
    import icache_pkg::*;

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int IDX_W   = $clog2(SETS);
    localparam int WAY_W   = $clog2(WAYS);
    localparam int BEATS   = LINE_BYTES * 8 / BEAT_W;
    localparam int BSEL_W  = $clog2(BEATS);
    localparam int BOFF_W  = $clog2(BEAT_W / 8);
    localparam int WSEL_W  = $clog2(BEAT_W / INSN_W);
    localparam int TAG_W   = PA_W - OFF_W - IDX_W;
    localparam int LINE_W  = PA_W - OFF_W;

    // ---------------- stage 0: accept and array read ----------------
    logic              accept;
    logic              refill_busy;
    logic [IDX_W-1:0]  s0_set;
    logic [BSEL_W-1:0] s0_beat;

    assign fetch_ready = !refill_busy;
    assign accept      = fetch_valid && fetch_ready;
    assign s0_set      = fetch_vaddr[OFF_W +: IDX_W];
    assign s0_beat     = fetch_vaddr[BOFF_W +: BSEL_W];

    // ---------------- stage 1: tag compare ----------------
    logic              s1_v;
    logic [IDX_W-1:0]  s1_set;
    logic [WSEL_W-1:0] s1_wsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_v    <= 1'b0;
            s1_set  <= '0;
            s1_wsel <= '0;
        end else begin
            s1_v    <= accept;
            s1_set  <= s0_set;
            s1_wsel <= fetch_vaddr[2 +: WSEL_W];
        end
    end

    logic [WAYS*TAG_W-1:0]  rd_tags;
    logic [WAYS-1:0]        s1_vld;
    logic [WAYS*BEAT_W-1:0] rd_row;
    logic [TAG_W-1:0]       s1_ptag;
    logic [WAYS-1:0]        hit_vec;
    logic [31:0]            s1_word;

    assign s1_ptag = lk_paddr[PA_W-1 -: TAG_W];

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_cmp
            assign hit_vec[w] = s1_vld[w] && (rd_tags[w*TAG_W +: TAG_W] == s1_ptag);
        end
    endgenerate

    always_comb begin
        s1_word = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w])
                s1_word = rd_row[w*BEAT_W + int'(s1_wsel)*INSN_W +: INSN_W];
        end
    end

    // ---------------- stage 2: response / miss ----------------
    logic              s2_v;
    logic              s2_hit;
    logic [31:0]       s2_word;
    logic [LINE_W-1:0] s2_line;
    logic              miss;

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_v    <= 1'b0;
            s2_hit  <= 1'b0;
            s2_word <= '0;
            s2_line <= '0;
        end else begin
            s2_v    <= s1_v && !kill_lookup;
            s2_hit  <= |hit_vec;
            s2_word <= s1_word;
            s2_line <= {s1_ptag, s1_set};
        end
    end

    assign insn_valid = s2_v && s2_hit && !kill_resp;
    assign insn_word  = s2_word;
    assign miss       = s2_v && !s2_hit && !kill_resp;

    // ---------------- refill machinery ----------------
    logic [7:0]        lfsr_q;
    refill_st_e        rf_state;
    logic              upd_en, mark_en, wr_en;
    logic [LINE_W-1:0] tgt_line;
    logic [WAY_W-1:0]  tgt_way;
    logic [BSEL_W-1:0] wr_beat;
    logic [BEAT_W-1:0] wr_data;

    icache_lfsr u_lfsr (.clk(clk), .rst(rst), .state(lfsr_q));

    icache_refill_ctl #(
        .LINE_W(LINE_W), .WAY_W(WAY_W), .BEATS(BEATS),
        .BEAT_W(BEAT_W), .OFF_W(OFF_W)
    ) u_ctl (
        .clk(clk), .rst(rst),
        .miss(miss), .miss_line(s2_line), .victim_in(lfsr_q[WAY_W-1:0]),
        .inv_all(inv_all),
        .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
        .fill_req_addr(fill_req_addr),
        .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data),
        .st_o(rf_state), .busy(refill_busy),
        .upd_en(upd_en), .mark_en(mark_en),
        .tgt_line(tgt_line), .tgt_way(tgt_way),
        .wr_en(wr_en), .wr_beat(wr_beat), .wr_data(wr_data)
    );

    icache_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .rd_set(s0_set), .rd_tags(rd_tags),
        .chk_set(s1_set), .chk_vld(s1_vld),
        .upd_en(upd_en), .upd_set(tgt_line[IDX_W-1:0]), .upd_way(tgt_way),
        .upd_tag(tgt_line[LINE_W-1 -: TAG_W]),
        .mark_en(mark_en), .mark_set(tgt_line[IDX_W-1:0]), .mark_way(tgt_way),
        .inv_all(inv_all)
    );

    icache_data_store #(.SETS(SETS), .WAYS(WAYS), .BEATS(BEATS), .BEAT_W(BEAT_W)) u_data (
        .clk(clk),
        .rd_set(s0_set), .rd_beat(s0_beat), .rd_row(rd_row),
        .wr_en(wr_en), .wr_set(tgt_line[IDX_W-1:0]), .wr_beat(wr_beat),
        .wr_way(tgt_way), .wr_data(wr_data)
    );
endmodule

// File: rtl/icache_pipe_chk.sv
module icache_pipe_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            fetch_valid,
    input logic            fetch_ready,
    input logic            kill_lookup,
    input logic            inv_all,
    input logic            insn_valid,
    input logic            fill_req_valid,
    input logic            fill_req_ready,
    input logic [PA_W-1:0] fill_req_addr
);
    // R3: a response always belongs to a fetch accepted two edges earlier
    p_resp_latency_r3: assert property (@(posedge clk) disable iff (rst)
        insn_valid |-> $past(fetch_valid && fetch_ready, 2));

    // R6: an access cancelled in the compare stage never responds
    p_kill_lookup_r6: assert property (@(posedge clk) disable iff (rst)
        $past(kill_lookup) |-> !insn_valid);

    // R5: once the fill request is taken, fetches are blocked
    p_ready_low_fill_r5: assert property (@(posedge clk) disable iff (rst)
        $past(fill_req_valid && fill_req_ready) |-> !fetch_ready);

    // R2 / R11: a pending fill request holds its address until taken
    p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (fill_req_valid && !fill_req_ready) |=> (fill_req_valid && $stable(fill_req_addr)));

    // R8: lookups compared after an invalidate cannot hit
    p_inv_blocks_hit_r8: assert property (@(posedge clk) disable iff (rst)
        $past(inv_all, 2) |-> !insn_valid);
endmodule

bind icache_pipe icache_pipe_chk #(.PA_W(PA_W)) u_chk (
    .clk(clk), .rst(rst),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready),
    .kill_lookup(kill_lookup), .inv_all(inv_all),
    .insn_valid(insn_valid),
    .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
    .fill_req_addr(fill_req_addr)
);

// File: tb/sim_icache_pipe.sv
module sim_icache_pipe;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0;
    logic        fetch_ready;
    logic [31:0] fetch_vaddr = '0;
    logic [31:0] lk_paddr = '0;
    logic        kill_lookup = 1'b0;
    logic        kill_resp = 1'b0;
    logic        inv_all = 1'b0;
    logic        insn_valid;
    logic [31:0] insn_word;
    logic        fill_req_valid;
    logic        fill_req_ready = 1'b0;
    logic [31:0] fill_req_addr;
    logic        fill_beat_valid = 1'b0;
    logic [63:0] fill_beat_data = '0;

    always #4 clk = ~clk;

    icache_pipe u0 (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_vaddr(fetch_vaddr),
        .lk_paddr(lk_paddr), .kill_lookup(kill_lookup), .kill_resp(kill_resp),
        .inv_all(inv_all), .insn_valid(insn_valid), .insn_word(insn_word),
        .fill_req_valid(fill_req_valid), .fill_req_ready(fill_req_ready),
        .fill_req_addr(fill_req_addr),
        .fill_beat_valid(fill_beat_valid), .fill_beat_data(fill_beat_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int n_req  = 0;
    int req_delay = 0;
    int cyc = 0;
    logic [31:0] last_addr = '0;

    function automatic logic [31:0] mword(input logic [31:0] a);
        return {a[31:2], 2'b00} ^ 32'hC3A5_0000;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    // memory model on the fill bus
    initial begin
        forever begin
            @(negedge clk);
            if (fill_req_valid && !rst) begin
                logic [31:0] a;
                repeat (req_delay) @(negedge clk);
                fill_req_ready = 1'b1;
                a = fill_req_addr;
                last_addr = a;
                n_req++;
                @(negedge clk);
                fill_req_ready = 1'b0;
                repeat (2) @(negedge clk);
                for (int b = 0; b < 8; b++) begin
                    fill_beat_valid = 1'b1;
                    fill_beat_data = {mword(a + 32'(8*b) + 32'd4), mword(a + 32'(8*b))};
                    // R5: fetches blocked while beats arrive
                    chk(fetch_ready == 1'b0, "R5 ready during beat", 64'(fetch_ready), 64'd0);
                    @(negedge clk);
                end
                fill_beat_valid = 1'b0;
            end
        end
    end

    task automatic fetch(input logic [31:0] va, input logic [31:0] pa, input bit k1, input bit k2,
                         output bit hit, output logic [31:0] w);
        @(negedge clk);
        fetch_valid = 1'b1;
        fetch_vaddr = va;
        while (!fetch_ready) @(negedge clk);
        @(negedge clk);
        fetch_valid = 1'b0;
        lk_paddr = pa;
        kill_lookup = k1;
        @(negedge clk);
        kill_lookup = 1'b0;
        kill_resp = k2;
        #1;
        hit = insn_valid;
        w = insn_word;
        @(posedge clk);
        #1 kill_resp = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [31:0] pa, output bit hit, output logic [31:0] w);
        fetch(pa, pa, 1'b0, 1'b0, hit, w);
        if (!hit) begin
            settle(30);
            fetch(pa, pa, 1'b0, 1'b0, hit, w);
        end
    endtask

    task automatic pulse_inv;
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    initial begin
        bit hit;
        logic [31:0] w;
        int n0;
        int hits;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(insn_valid == 1'b0, "R1 insn_valid", 64'(insn_valid), 64'd0);
        chk(fill_req_valid == 1'b0, "R1 fill_req_valid", 64'(fill_req_valid), 64'd0);
        chk(fetch_ready == 1'b1, "R1 fetch_ready", 64'(fetch_ready), 64'd1);

        // R2 cold miss and request address
        fetch(32'h0000_1048, 32'h0000_1048, 1'b0, 1'b0, hit, w);
        chk(!hit, "R2 cold miss no resp", 64'(hit), 64'd0);
        settle(30);
        chk(n_req == 1, "R2 one request", 64'(n_req), 64'd1);
        chk(last_addr == 32'h0000_1040, "R2 aligned addr", 64'(last_addr), 64'h1040);
        fetch(32'h0000_1048, 32'h0000_1048, 1'b0, 1'b0, hit, w);
        chk(hit, "R3 hit after refill", 64'(hit), 64'd1);
        chk(w == mword(32'h0000_1048), "R3 word", 64'(w), 64'(mword(32'h0000_1048)));

        // R3 sweep over all sets
        for (int s = 0; s < 64; s++) begin
            logic [31:0] pa;
            pa = 32'h0040_0000 | 32'(s << 6) | 32'((s % 16) << 2);
            load(pa, hit, w);
            chk(hit, "R3 sweep hit", 64'(hit), 64'd1);
            chk(w == mword(pa), "R3 sweep word", 64'(w), 64'(mword(pa)));
        end
        // R3 every word of a few lines
        for (int k = 0; k < 3; k++) begin
            logic [31:0] base;
            base = 32'h0040_0000 | 32'((k == 0 ? 0 : (k == 1 ? 21 : 63)) << 6);
            for (int o = 0; o < 16; o++) begin
                fetch(base + 32'(o*4), base + 32'(o*4), 1'b0, 1'b0, hit, w);
                chk(hit && w == mword(base + 32'(o*4)), "R3 word offset",
                    64'(w), 64'(mword(base + 32'(o*4))));
            end
        end

        // R4 tag from physical address only
        fetch(32'hABC0_00C4 ^ 32'h0040_0000, 32'h0040_00C4, 1'b0, 1'b0, hit, w);
        chk(hit && w == mword(32'h0040_00C4), "R4 virtual upper bits ignored", 64'(w), 64'(mword(32'h0040_00C4)));
        fetch(32'h0040_00C4, 32'h0041_00C4, 1'b0, 1'b0, hit, w);
        chk(!hit, "R4 other tag misses", 64'(hit), 64'd0);
        settle(30);

        // R6 kill in compare stage on an uncached line
        n0 = n_req;
        fetch(32'h0777_0080, 32'h0777_0080, 1'b1, 1'b0, hit, w);
        chk(!hit, "R6 killed no resp", 64'(hit), 64'd0);
        settle(30);
        chk(n_req == n0, "R6 killed no refill", 64'(n_req), 64'(n0));
        fetch(32'h0777_0080, 32'h0777_0080, 1'b0, 1'b0, hit, w);
        chk(!hit, "R6 line still absent", 64'(hit), 64'd0);
        settle(30);

        // R7 kill in response stage
        fetch(32'h0040_0000, 32'h0040_0000, 1'b0, 1'b1, hit, w);
        chk(!hit, "R7 killed hit no resp", 64'(hit), 64'd0);
        n0 = n_req;
        fetch(32'h0555_0100, 32'h0555_0100, 1'b0, 1'b1, hit, w);
        settle(30);
        chk(n_req == n0, "R7 killed miss no refill", 64'(n_req), 64'(n0));

        // R11 second miss while a refill waits
        req_delay = 20;
        n0 = n_req;
        fetch(32'h0900_0280, 32'h0900_0280, 1'b0, 1'b0, hit, w);
        fetch(32'h0900_02C0, 32'h0900_02C0, 1'b0, 1'b0, hit, w);
        chk(!hit, "R11 busy miss no resp", 64'(hit), 64'd0);
        settle(50);
        chk(n_req == n0 + 1, "R11 single request", 64'(n_req), 64'(n0 + 1));
        chk(last_addr == 32'h0900_0280, "R11 first line fetched", 64'(last_addr), 64'h0900_0280);
        fetch(32'h0900_0284, 32'h0900_0284, 1'b0, 1'b0, hit, w);
        chk(hit && w == mword(32'h0900_0284), "R11 first line hits", 64'(w), 64'(mword(32'h0900_0284)));

        // R9 invalidate during refill
        fetch(32'h0A00_0300, 32'h0A00_0300, 1'b0, 1'b0, hit, w);
        pulse_inv();
        settle(50);
        req_delay = 0;
        n0 = n_req;
        fetch(32'h0A00_0300, 32'h0A00_0300, 1'b0, 1'b0, hit, w);
        chk(!hit, "R9 aborted line misses", 64'(hit), 64'd0);
        settle(30);
        chk(n_req == n0 + 1, "R9 refetched", 64'(n_req), 64'(n0 + 1));

        // R8 invalidate drops everything
        load(32'h0040_0008, hit, w);
        chk(hit, "R8 line present before", 64'(hit), 64'd1);
        pulse_inv();
        for (int s = 0; s < 64; s++) begin
            logic [31:0] pa;
            pa = 32'h0040_0000 | 32'(s << 6);
            fetch(pa, pa, 1'b0, 1'b0, hit, w);
            chk(!hit, "R8 miss after invalidate", 64'(hit), 64'd0);
            settle(30);
        end

        // R10 replacement within one set
        for (int t = 1; t <= 6; t++) begin
            logic [31:0] pa;
            pa = 32'(t << 16) | 32'(20 << 6);
            load(pa, hit, w);
            chk(hit && w == mword(pa), "R10 fresh line hits", 64'(w), 64'(mword(pa)));
        end
        hits = 0;
        for (int t = 6; t >= 1; t--) begin
            logic [31:0] pa;
            pa = 32'(t << 16) | 32'(20 << 6);
            fetch(pa, pa, 1'b0, 1'b0, hit, w);
            if (t == 6) chk(hit, "R10 newest line hits", 64'(hit), 64'd1);
            if (hit) hits++;
            settle(30);
        end
        chk(hits >= 1 && hits <= 4, "R10 at most ways tags", 64'(hits), 64'd4);
        fetch(32'h0040_0544, 32'h0040_0544, 1'b0, 1'b0, hit, w);
        chk(hit && w == mword(32'h0040_0544), "R10 other set untouched", 64'(w), 64'(mword(32'h0040_0544)));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule